// File: doc/BRIEF.md
# Directory Overflow Bit-Vector Extender

This block is the hardware assist for one directory entry whose limited set of sharer pointers has run out. When the protocol engine hands it an overflow command, it walks the pointer slots in order. It copies each valid pointer into a full-map vector that has one bit per node, and it empties the slot. After the first overflow the entry's mode becomes Trap-On-Write. Later overflows fold the new pointers into the same vector.

A terminate command is issued when a write request or a local write fault reaches an overflowed entry. The block drains the pointers once more and stores the requester in pointer slot 0. It loads the acknowledgement counter with the number of bits set in the vector and returns the entry to Normal mode, flagged as being in a write transaction. It then sends one invalidation per cycle to every marked node, lowest node first, and clears each bit as its invalidation leaves. A one-cycle done pulse closes every sequence. A command offered while a sequence is running is refused and has no effect.

Top module: `dir_overflow_extender`

## Requirements
- R1: After reset the block shows cmdReady=1, done=0, invValid=0, dirMode=0 (Normal), writeTxn=0, vecAlloc=0 and ackCtr=0.
- R2: An accepted command of either kind visits pointer slots 0 to PTRS-1 in ascending order, one per cycle, starting in the cycle after acceptance. Each visit writes the slot with ptrWe=1 and ptrWrVld=0, which empties it.
- R3: During a drain, each visited slot that holds a valid pointer sets the vector bit of the node it names. Slots that are not valid set nothing, and a node named twice is marked once.
- R4: The first overflow (cmdOp=0) accepted while vecAlloc=0 starts from a cleared vector and raises vecAlloc. Once any overflow finishes, dirMode=1 (Trap-On-Write).
- R5: An overflow accepted while vecAlloc=1 keeps the bits already in the vector and adds the drained pointers to them.
- R6: On a terminate (cmdOp=1), after the drain the requester ID is written into slot 0 with ptrWrVld=1. ackCtr is loaded with the population count of the vector, including the bits from that drain.
- R7: A terminate leaves dirMode=0, writeTxn=1 and vecAlloc=0. An accepted overflow clears writeTxn.
- R8: After the slot-0 write, a terminate sends one invalidation per cycle (invValid=1, invNode=node) for every set bit, in ascending node order and each exactly once. It leaves the vector empty.
- R9: done is high for exactly one cycle. For an overflow it rises in the (PTRS+1)-th cycle after acceptance. For a terminate that sends n invalidations it rises in the (PTRS+2+n)-th cycle. cmdReady is high again in the following cycle.
- R10: While a sequence is running cmdReady is 0, and a command offered then is dropped: it changes no output and no later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdOp | input | 1 | 0 = overflow, 1 = terminate |
| cmdReqId | input | IDW | Requester node for terminate |
| cmdReady | output | 1 | Block idle; command taken when cmdValid is high |
| ptrIdx | output | PW | Pointer slot being read or written |
| ptrRdVld | input | 1 | Valid bit of slot ptrIdx |
| ptrRdId | input | IDW | Node ID held in slot ptrIdx |
| ptrWe | output | 1 | Write slot ptrIdx at the clock edge |
| ptrWrVld | output | 1 | Valid bit to write |
| ptrWrId | output | IDW | Node ID to write |
| dirMode | output | 1 | 0 = Normal, 1 = Trap-On-Write |
| writeTxn | output | 1 | Entry is in a write transaction |
| vecAlloc | output | 1 | Full-map vector in use |
| ackCtr | output | CW | Acknowledgement counter |
| invValid | output | 1 | Invalidation emitted this cycle |
| invNode | output | IDW | Node to invalidate |
| done | output | 1 | Sequence finished (one-cycle pulse) |

## Verification
The hardest case to reach is a terminate whose vector holds bits from several earlier overflows, duplicate pointers and the nodes at both ends of the range. Only then do the invalidation order, the popcount and the clearing of each bit show together. The stimulus therefore chains random overflows over freshly loaded random pointer slots before each random terminate. It also includes directed runs that place node 0, node 63 and a repeated node in the slots. A second terminate right after the first confirms the vector was emptied. Commands are also injected mid-sequence to confirm they are refused.

// File: rtl/dovx_pkg.sv
package dovx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DRAIN,
    S_WRAP,
    S_RECORD,
    S_INV
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startOvf;
    logic startTerm;
    logic drainStep;
    logic setTow;
    logic finishTerm;
    logic invStep;
  } dpStrobe_t;

endpackage

// File: rtl/dovx_datapath.sv
module dovx_datapath
  import dovx_pkg::*;
#(
  parameter int NODES = 64,
  parameter int PTRS  = 4,
  localparam int IDW = $clog2(NODES),
  localparam int CW  = $clog2(NODES + 1),
  localparam int PW  = (PTRS > 1) ? $clog2(PTRS) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpStrobe_t      strobe,
  input  logic [IDW-1:0] cmdReqId,
  input  logic           ptrRdVld,
  input  logic [IDW-1:0] ptrRdId,
  output logic [PW-1:0]  ptrIdx,
  output logic [IDW-1:0] reqId,
  output logic           idxLast,
  output logic           vecEmpty,
  output logic           vecAlloc,
  output logic           dirMode,
  output logic           writeTxn,
  output logic [CW-1:0]  ackCtr,
  output logic [IDW-1:0] invNode
);

  logic [NODES-1:0] vec, vecNext;
  logic [PW-1:0]    idx;
  logic [CW-1:0]    setCount;
  logic [IDW-1:0]   lowIdx;

  function automatic logic [CW-1:0] popCount(input logic [NODES-1:0] v);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < NODES; i++) c = c + CW'(v[i]);
    return c;
  endfunction

  always_comb begin
    lowIdx = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (vec[i]) lowIdx = IDW'(i);
    end
  end

  assign setCount = popCount(vec);
  assign vecEmpty = (vec == '0);
  assign idxLast  = (idx == PW'(PTRS - 1));
  assign ptrIdx   = idx;
  assign invNode  = lowIdx;

  always_comb begin
    vecNext = vec;
    if (strobe.startOvf && !vecAlloc) vecNext = '0;
    if (strobe.drainStep && ptrRdVld) vecNext[ptrRdId] = 1'b1;
    if (strobe.invStep && !vecEmpty) vecNext[lowIdx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vec      <= '0;
      idx      <= '0;
      reqId    <= '0;
      vecAlloc <= 1'b0;
      dirMode  <= 1'b0;
      writeTxn <= 1'b0;
      ackCtr   <= '0;
    end else begin
      vec <= vecNext;
      if (strobe.startOvf) begin
        vecAlloc <= 1'b1;
        writeTxn <= 1'b0;
        idx      <= '0;
      end
      if (strobe.startTerm) begin
        reqId <= cmdReqId;
        idx   <= '0;
      end
      if (strobe.drainStep) idx <= idxLast ? '0 : idx + 1'b1;
      if (strobe.setTow) dirMode <= 1'b1;
      if (strobe.finishTerm) begin
        ackCtr   <= setCount;
        dirMode  <= 1'b0;
        writeTxn <= 1'b1;
        vecAlloc <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dovx_control.sv
module dovx_control
  import dovx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      cmdOp,
  input  logic      idxLast,
  input  logic      vecEmpty,
  output dpStrobe_t strobe,
  output logic      cmdReady,
  output logic      ptrWe,
  output logic      ptrWrVld,
  output logic      invValid,
  output logic      done
);

  ctlState_t state, stateNext;
  logic      isTerm;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    cmdReady  = 1'b0;
    ptrWe     = 1'b0;
    ptrWrVld  = 1'b0;
    invValid  = 1'b0;
    done      = 1'b0;
    unique case (state)
      S_IDLE: begin
        cmdReady = 1'b1;
        if (cmdValid) begin
          strobe.startOvf  = !cmdOp;
          strobe.startTerm = cmdOp;
          stateNext        = S_DRAIN;
        end
      end
      S_DRAIN: begin
        strobe.drainStep = 1'b1;
        ptrWe            = 1'b1;
        if (idxLast) stateNext = isTerm ? S_RECORD : S_WRAP;
      end
      S_WRAP: begin
        strobe.setTow = 1'b1;
        done          = 1'b1;
        stateNext     = S_IDLE;
      end
      S_RECORD: begin
        ptrWe             = 1'b1;
        ptrWrVld          = 1'b1;
        strobe.finishTerm = 1'b1;
        stateNext         = S_INV;
      end
      S_INV: begin
        strobe.invStep = 1'b1;
        invValid       = !vecEmpty;
        if (vecEmpty) begin
          done      = 1'b1;
          stateNext = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      isTerm <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && cmdValid) isTerm <= cmdOp;
    end
  end

endmodule

// File: rtl/dir_overflow_extender.sv
module dir_overflow_extender
  import dovx_pkg::*;
#(
  parameter int NODES = 64,
  parameter int PTRS  = 4,
  localparam int IDW = $clog2(NODES),
  localparam int CW  = $clog2(NODES + 1),
  localparam int PW  = (PTRS > 1) ? $clog2(PTRS) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmdValid,
  input  logic           cmdOp,
  input  logic [IDW-1:0] cmdReqId,
  output logic           cmdReady,
  output logic [PW-1:0]  ptrIdx,
  input  logic           ptrRdVld,
  input  logic [IDW-1:0] ptrRdId,
  output logic           ptrWe,
  output logic           ptrWrVld,
  output logic [IDW-1:0] ptrWrId,
  output logic           dirMode,
  output logic           writeTxn,
  output logic           vecAlloc,
  output logic [CW-1:0]  ackCtr,
  output logic           invValid,
  output logic [IDW-1:0] invNode,
  output logic           done
);

  dpStrobe_t strobe;
  logic      idxLast, vecEmpty;

  dovx_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .idxLast  (idxLast),
    .vecEmpty (vecEmpty),
    .strobe   (strobe),
    .cmdReady (cmdReady),
    .ptrWe    (ptrWe),
    .ptrWrVld (ptrWrVld),
    .invValid (invValid),
    .done     (done)
  );

  dovx_datapath #(.NODES(NODES), .PTRS(PTRS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdReqId (cmdReqId),
    .ptrRdVld (ptrRdVld),
    .ptrRdId  (ptrRdId),
    .ptrIdx   (ptrIdx),
    .reqId    (ptrWrId),
    .idxLast  (idxLast),
    .vecEmpty (vecEmpty),
    .vecAlloc (vecAlloc),
    .dirMode  (dirMode),
    .writeTxn (writeTxn),
    .ackCtr   (ackCtr),
    .invNode  (invNode)
  );

endmodule

// File: rtl/dovx_checker.sv
module dovx_checker #(
  parameter int IDW = 6,
  parameter int PW  = 2
) (
  input logic           clk,
  input logic           rstN,
  input logic           cmdValid,
  input logic           cmdReady,
  input logic [PW-1:0]  ptrIdx,
  input logic           ptrWe,
  input logic           ptrWrVld,
  input logic           dirMode,
  input logic           writeTxn,
  input logic           invValid,
  input logic [IDW-1:0] invNode,
  input logic           done
);

  // R8
  inv_ascending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && $past(invValid)) |-> (invNode > $past(invNode)));

  // R7
  inv_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> (!dirMode && writeTxn));

  // R9
  done_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (cmdReady && !done));

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  // R6
  record_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ptrWe && ptrWrVld) |-> (ptrIdx == '0));

  // R8
  inv_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> !cmdReady);

endmodule

bind dir_overflow_extender dovx_checker #(.IDW(IDW), .PW(PW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .ptrIdx   (ptrIdx),
  .ptrWe    (ptrWe),
  .ptrWrVld (ptrWrVld),
  .dirMode  (dirMode),
  .writeTxn (writeTxn),
  .invValid (invValid),
  .invNode  (invNode),
  .done     (done)
);

// File: tb/test_dir_overflow_extender.sv
module test_dir_overflow_extender;

  localparam int CLK_PERIOD = 10;
  localparam int NODES = 64;
  localparam int PTRS  = 4;
  localparam int IDW = 6;
  localparam int CW  = 7;
  localparam int PW  = 2;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           cmdValid = 1'b0;
  logic           cmdOp = 1'b0;
  logic [IDW-1:0] cmdReqId = '0;
  logic           cmdReady;
  logic [PW-1:0]  ptrIdx;
  logic           ptrRdVld;
  logic [IDW-1:0] ptrRdId;
  logic           ptrWe, ptrWrVld;
  logic [IDW-1:0] ptrWrId;
  logic           dirMode, writeTxn, vecAlloc;
  logic [CW-1:0]  ackCtr;
  logic           invValid;
  logic [IDW-1:0] invNode;
  logic           done;

  logic           pv  [PTRS];
  logic [IDW-1:0] pid [PTRS];

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [NODES-1:0] expVec = '0;
  bit expAlloc = 0, expMode = 0, expWtx = 0;
  int expAck = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ptrRdVld = pv[ptrIdx];
  assign ptrRdId  = pid[ptrIdx];

  always @(posedge clk) begin
    if (ptrWe) begin
      pv[ptrIdx]  <= ptrWrVld;
      pid[ptrIdx] <= ptrWrId;
    end
  end

  dir_overflow_extender #(.NODES(NODES), .PTRS(PTRS)) i_dir_overflow_extender (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdReqId(cmdReqId),
    .cmdReady(cmdReady), .ptrIdx(ptrIdx), .ptrRdVld(ptrRdVld), .ptrRdId(ptrRdId),
    .ptrWe(ptrWe), .ptrWrVld(ptrWrVld), .ptrWrId(ptrWrId), .dirMode(dirMode),
    .writeTxn(writeTxn), .vecAlloc(vecAlloc), .ackCtr(ackCtr), .invValid(invValid),
    .invNode(invNode), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int popc(input logic [NODES-1:0] v);
    int c = 0;
    for (int i = 0; i < NODES; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic loadPtrs(input bit v0, input int i0, input bit v1, input int i1,
                          input bit v2, input int i2, input bit v3, input int i3);
    pv[0] = v0; pid[0] = IDW'(i0);
    pv[1] = v1; pid[1] = IDW'(i1);
    pv[2] = v2; pid[2] = IDW'(i2);
    pv[3] = v3; pid[3] = IDW'(i3);
  endtask

  // Drive one command starting at a negedge; return at a negedge after done.
  task automatic runCmd(input bit op, input int req, input bit inject);
    int n, nInv, drainCnt, k, expDone;
    int got [NODES];
    logic [NODES-1:0] v;
    nInv = 0; drainCnt = 0;
    // model
    if (!op && !expAlloc) expVec = '0;
    for (int i = 0; i < PTRS; i++) if (pv[i]) expVec[pid[i]] = 1'b1;
    check(cmdReady == 1'b1, "R9 ready before command", int'(cmdReady), 1);
    cmdValid = 1'b1; cmdOp = op; cmdReqId = IDW'(req);
    @(negedge clk);
    cmdValid = 1'b0;
    n = 1;
    forever begin
      if (ptrWe && !ptrWrVld) begin
        check(int'(ptrIdx) == drainCnt && drainCnt < PTRS, "R2 drain slot order",
              int'(ptrIdx), drainCnt);
        drainCnt++;
      end
      if (ptrWe && ptrWrVld)
        check(int'(ptrWrId) == req && ptrIdx == '0, "R6 requester record",
              int'(ptrWrId), req);
      if (invValid && nInv < NODES) begin got[nInv] = int'(invNode); nInv++; end
      if (done) break;
      if (inject && n == 2) begin
        check(cmdReady == 1'b0, "R10 ready low while busy", int'(cmdReady), 0);
        cmdValid = 1'b1; cmdOp = !op; cmdReqId = IDW'(req ^ 5);
      end else begin
        cmdValid = 1'b0;
      end
      n++;
      if (n > 300) begin
        check(0, "R9 sequence never finished", n, 0);
        break;
      end
      @(negedge clk);
    end
    cmdValid = 1'b0;
    check(drainCnt == PTRS, "R2 slots drained", drainCnt, PTRS);
    if (!op) begin
      expAlloc = 1; expMode = 1; expWtx = 0; expDone = PTRS + 1;
      check(nInv == 0, "R4 no invalidation on overflow", nInv, 0);
    end else begin
      expAck = popc(expVec);
      expDone = PTRS + 2 + expAck;
      v = expVec; k = 0;
      for (int i = 0; i < NODES; i++) begin
        if (v[i]) begin
          if (k < nInv) check(got[k] == i, "R8 invalidation node", got[k], i);
          k++;
        end
      end
      check(nInv == expAck, "R8 invalidation count", nInv, expAck);
      expVec = '0; expAlloc = 0; expMode = 0; expWtx = 1;
    end
    check(n == expDone, "R9 done cycle", n, expDone);
    @(negedge clk);
    check(cmdReady && !done, "R9 ready after done", int'(cmdReady), 1);
    check(int'(dirMode) == int'(expMode), "R4 R7 mode", int'(dirMode), int'(expMode));
    check(int'(writeTxn) == int'(expWtx), "R7 write transaction", int'(writeTxn), int'(expWtx));
    check(int'(vecAlloc) == int'(expAlloc), "R4 R7 vector allocated", int'(vecAlloc), int'(expAlloc));
    check(int'(ackCtr) == expAck, "R6 ack counter", int'(ackCtr), expAck);
    for (int i = 0; i < PTRS; i++) begin
      if (op && i == 0)
        check(pv[0] && int'(pid[0]) == req, "R6 slot 0 holds requester", int'(pid[0]), req);
      else
        check(!pv[i], "R2 slot emptied", int'(pv[i]), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    loadPtrs(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cmdReady && !done && !invValid, "R1 reset handshake", int'(cmdReady), 1);
    check(!dirMode && !writeTxn && !vecAlloc, "R1 reset mode", int'(dirMode), 0);
    check(ackCtr == '0, "R1 reset ack", int'(ackCtr), 0);

    // R3 R4 first overflow: node 0, node 63, duplicate, empty slot
    loadPtrs(1, 0, 1, 63, 0, 20, 1, 63);
    runCmd(0, 0, 1);
    // R5 second overflow accumulates
    loadPtrs(0, 9, 1, 31, 1, 0, 0, 0);
    runCmd(0, 0, 0);
    // R6 R8 terminate with more pointers, command injected while busy (R10)
    loadPtrs(1, 32, 0, 0, 0, 0, 1, 1);
    runCmd(1, 7, 1);
    // R8 vector left empty: terminate with no pointers
    loadPtrs(0, 0, 0, 0, 0, 0, 0, 0);
    runCmd(1, 63, 0);
    // R7 overflow clears write transaction, all slots full
    loadPtrs(1, 62, 1, 61, 1, 60, 1, 59);
    runCmd(0, 0, 0);
    runCmd(1, 0, 1);

    // random chains
    for (int it = 0; it < 60; it++) begin
      for (int s = 0; s < PTRS; s++) begin
        pv[s]  = ($urandom % 4) != 0;
        pid[s] = IDW'($urandom % NODES);
      end
      runCmd(($urandom % 10) < 3, int'($urandom % NODES), ($urandom % 4) == 0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule